// File: doc/BRIEF.md
# Thread-Block Work Distributor

This block spreads the independent thread blocks of one grid across a parameterised number of multiprocessor slots. A grid is launched with its width and height in blocks, the shape of each block in threads (x, y and z extents; a one- or two-dimensional shape simply sets the unused extents to 1), and the shared-memory bytes each block needs. The block size is the product of the three extents. The distributor keeps its own ledger of free threads and free shared memory for every slot. It charges a slot when a block is handed to it. It credits the slot back when that slot reports completion, together with the amounts it returns.

Blocks leave over one dispatch channel that carries the target slot index, the block coordinates and the resource amounts. Back-pressure rules: once `disp_valid` is high, the slot index, coordinates and amounts stay unchanged until a cycle in which `disp_ready` is also high. The transfer takes place on that clock edge. `disp_valid` never drops without a transfer. The launch channel follows the same valid/ready rule. `launch_ready` is high exactly when no grid is in progress, so a second grid waits at the port until the first one has fully drained. Completion inputs and the grid-done and error outputs are plain single-cycle pulses.

Top module: `wd_block_dist`

## Requirements
- R1: `launch_ready` is high if and only if no grid is in progress. A launch offered while a grid runs is held off until the cycle after `grid_done`, so no block of a later grid is issued before every block of the earlier grid has completed.
- R2: A launch is rejected if any of the following holds: the block size (x*y*z) is below 1 or above 512, the shared-memory request exceeds 16384 bytes, or a grid dimension is zero. A rejected launch is still consumed. It raises `launch_err` for one cycle, in the cycle after the transfer, and starts no grid.
- R3: A block is dispatched to a slot only if the block size does not exceed that slot's free threads. Each slot starts with 768 free threads. `disp_threads` carries the block size.
- R4: A block is dispatched to a slot only if its shared-memory request does not exceed that slot's free shared memory. Each slot starts with 16384 free bytes.
- R5: Block coordinates are issued in raster order: x increments first, then y. Every block of the grid is issued exactly once.
- R6: While `disp_valid` is high and `disp_ready` is low, `disp_slot`, `disp_blk_x` and `disp_blk_y` hold their values on the next cycle.
- R7: The slot is chosen round-robin. The search starts at the slot after the one chosen last (slot 0 after reset) and takes the first slot with room.
- R8: A `done_valid[s]` pulse returns `done_threads` and `done_smem` for slot s. These amounts are credited on the same edge and can be used for the next block.
- R9: `grid_done` pulses for exactly one cycle, in the cycle after the edge on which the last outstanding completion is sampled. `launch_ready` rises in that same cycle.
- R10: After reset, `launch_ready` is 1 and `disp_valid`, `grid_done` and `launch_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | No grid in progress; launch accepted |
| launch_grid_x | input | 8 | Grid width in blocks |
| launch_grid_y | input | 8 | Grid height in blocks |
| launch_blk_x | input | DIM_W | Block x extent in threads |
| launch_blk_y | input | DIM_W | Block y extent in threads |
| launch_blk_z | input | DIM_W | Block z extent in threads |
| launch_smem | input | SMEM_W | Shared-memory bytes per block |
| launch_err | output | 1 | Pulse: last launch rejected |
| disp_valid | output | 1 | Block offered to a slot |
| disp_ready | input | 1 | Slot side accepts the offer |
| disp_slot | output | IDX_W | Target slot index |
| disp_blk_x | output | 8 | Block x coordinate |
| disp_blk_y | output | 8 | Block y coordinate |
| disp_threads | output | THR_W | Threads the block occupies |
| disp_smem | output | SMEM_W | Shared-memory bytes the block occupies |
| done_valid | input | NUM_SLOTS | Per-slot completion pulse |
| done_threads | input | NUM_SLOTS*THR_W | Threads freed, per slot |
| done_smem | input | NUM_SLOTS*SMEM_W | Shared-memory bytes freed, per slot |
| grid_done | output | 1 | Pulse: every block of the grid completed |

## Verification
The assertions check the following on every cycle: neither ledger ever rises above slot capacity, the dispatch payload holds under back-pressure, the picked slot really has room, no block is offered while idle, a reject never starts a grid, and `grid_done` is a single pulse. Only the bench scenarios can show the rest. These are raster ordering, exact round-robin slot sequences, a block being refused because one of the two resources is exhausted while the other is free, capacity being reused after completions, and a second launch being held until the first grid has drained.

// File: rtl/wd_pkg.sv
package wd_pkg;
  parameter int unsigned WD_GDIM_W = 8;

  typedef struct packed {
    logic [WD_GDIM_W-1:0] y;
    logic [WD_GDIM_W-1:0] x;
  } wd_blk_id_t;
endpackage

// File: rtl/wd_launch_check.sv
module wd_launch_check #(
  parameter int unsigned DIM_W     = 10,
  parameter int unsigned SMEM_W    = 15,
  parameter int unsigned GDIM_W    = 8,
  parameter int unsigned MAX_BLK   = 512,
  parameter int unsigned SLOT_SMEM = 16384,
  localparam int unsigned PROD_W   = 3*DIM_W
) (
  input  logic [DIM_W-1:0]  bx,
  input  logic [DIM_W-1:0]  by,
  input  logic [DIM_W-1:0]  bz,
  input  logic [SMEM_W-1:0] smem,
  input  logic [GDIM_W-1:0] gx,
  input  logic [GDIM_W-1:0] gy,
  output logic [PROD_W-1:0] size,
  output logic              ok
);
  always_comb begin
    size = PROD_W'(bx) * PROD_W'(by) * PROD_W'(bz);
    ok   = (size != '0) && (size <= PROD_W'(MAX_BLK)) &&
           (smem <= SMEM_W'(SLOT_SMEM)) && (gx != '0) && (gy != '0);
  end
endmodule

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     fit,
  input  logic [IDX_W-1:0] ptr,
  output logic             any,
  output logic [IDX_W-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = N-1; k >= 0; k--) begin
      int unsigned idx;
      idx = (int'(ptr) + k) % N;
      if (fit[idx]) begin
        any = 1'b1;
        sel = IDX_W'(idx);
      end
    end
  end

  AST_PICK_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> fit[sel]); // R7
endmodule

// File: rtl/wd_slot_ledger.sv
module wd_slot_ledger #(
  parameter int unsigned SLOT_THREADS = 768,
  parameter int unsigned SLOT_SMEM    = 16384,
  localparam int unsigned THR_W       = $clog2(SLOT_THREADS+1),
  localparam int unsigned SMEM_W      = $clog2(SLOT_SMEM+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [THR_W-1:0]  need_thr,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic              ret,
  input  logic [THR_W-1:0]  ret_thr,
  input  logic [SMEM_W-1:0] ret_smem,
  output logic              fit
);
  logic [THR_W-1:0]  free_thr;
  logic [SMEM_W-1:0] free_smem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_thr  <= THR_W'(SLOT_THREADS);
      free_smem <= SMEM_W'(SLOT_SMEM);
    end else begin
      free_thr  <= free_thr - (take ? need_thr : '0) + (ret ? ret_thr : '0);
      free_smem <= free_smem - (take ? need_smem : '0) + (ret ? ret_smem : '0);
    end
  end

  assign fit = (free_thr >= need_thr) && (free_smem >= need_smem);

  AST_THR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    free_thr <= THR_W'(SLOT_THREADS)); // R3
  AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    free_smem <= SMEM_W'(SLOT_SMEM)); // R4
endmodule

// File: rtl/wd_block_dist.sv
module wd_block_dist #(
  parameter int unsigned NUM_SLOTS       = 4,
  parameter int unsigned SLOT_THREADS    = 768,
  parameter int unsigned SLOT_SMEM       = 16384,
  parameter int unsigned MAX_BLK_THREADS = 512,
  parameter int unsigned DIM_W           = 10,
  localparam int unsigned THR_W  = $clog2(SLOT_THREADS+1),
  localparam int unsigned SMEM_W = $clog2(SLOT_SMEM+1),
  localparam int unsigned IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned GDIM_W = wd_pkg::WD_GDIM_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch_valid,
  output logic                        launch_ready,
  input  logic [GDIM_W-1:0]           launch_grid_x,
  input  logic [GDIM_W-1:0]           launch_grid_y,
  input  logic [DIM_W-1:0]            launch_blk_x,
  input  logic [DIM_W-1:0]            launch_blk_y,
  input  logic [DIM_W-1:0]            launch_blk_z,
  input  logic [SMEM_W-1:0]           launch_smem,
  output logic                        launch_err,
  output logic                        disp_valid,
  input  logic                        disp_ready,
  output logic [IDX_W-1:0]            disp_slot,
  output logic [GDIM_W-1:0]           disp_blk_x,
  output logic [GDIM_W-1:0]           disp_blk_y,
  output logic [THR_W-1:0]            disp_threads,
  output logic [SMEM_W-1:0]           disp_smem,
  input  logic [NUM_SLOTS-1:0]        done_valid,
  input  logic [NUM_SLOTS*THR_W-1:0]  done_threads,
  input  logic [NUM_SLOTS*SMEM_W-1:0] done_smem,
  output logic                        grid_done
);
  import wd_pkg::*;

  localparam int unsigned CNT_W  = 2*GDIM_W + 1;
  localparam int unsigned PROD_W = 3*DIM_W;

  logic              active, all_loaded;
  wd_blk_id_t        nxt, lim, disp_id;
  logic [THR_W-1:0]  blk_thr;
  logic [SMEM_W-1:0] blk_smem;
  logic [IDX_W-1:0]  rr_ptr, sel;
  logic [NUM_SLOTS-1:0] fit;
  logic              any_fit;
  logic [CNT_W-1:0]  outstanding, ndone, out_next;
  logic [PROD_W-1:0] req_size;
  logic              req_ok, launch_fire, load, finish, last_blk;

  wd_launch_check #(
    .DIM_W(DIM_W), .SMEM_W(SMEM_W), .GDIM_W(GDIM_W),
    .MAX_BLK(MAX_BLK_THREADS), .SLOT_SMEM(SLOT_SMEM)
  ) u_check (
    .bx(launch_blk_x), .by(launch_blk_y), .bz(launch_blk_z),
    .smem(launch_smem), .gx(launch_grid_x), .gy(launch_grid_y),
    .size(req_size), .ok(req_ok)
  );

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      wd_slot_ledger #(.SLOT_THREADS(SLOT_THREADS), .SLOT_SMEM(SLOT_SMEM)) u_ledger (
        .clk(clk), .rst_n(rst_n),
        .take(load && (sel == IDX_W'(s))),
        .need_thr(blk_thr), .need_smem(blk_smem),
        .ret(done_valid[s]),
        .ret_thr(done_threads[s*THR_W +: THR_W]),
        .ret_smem(done_smem[s*SMEM_W +: SMEM_W]),
        .fit(fit[s])
      );
    end
  endgenerate

  wd_rr_pick #(.N(NUM_SLOTS)) u_pick (
    .clk(clk), .rst_n(rst_n), .fit(fit), .ptr(rr_ptr), .any(any_fit), .sel(sel)
  );

  assign launch_ready = !active;
  assign launch_fire  = launch_valid && !active;
  assign load         = active && !all_loaded && any_fit && (!disp_valid || disp_ready);
  assign last_blk     = (nxt.x == lim.x - 1'b1) && (nxt.y == lim.y - 1'b1);
  assign ndone        = CNT_W'($countones(done_valid));
  assign out_next     = outstanding + CNT_W'(load) - ndone;
  assign finish       = active && all_loaded && (ndone != '0) && (out_next == '0);

  assign disp_blk_x   = disp_id.x;
  assign disp_blk_y   = disp_id.y;
  assign disp_threads = blk_thr;
  assign disp_smem    = blk_smem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      all_loaded  <= 1'b0;
      nxt         <= '0;
      lim         <= '0;
      disp_id     <= '0;
      disp_valid  <= 1'b0;
      disp_slot   <= '0;
      blk_thr     <= '0;
      blk_smem    <= '0;
      rr_ptr      <= '0;
      outstanding <= '0;
      grid_done   <= 1'b0;
      launch_err  <= 1'b0;
    end else begin
      grid_done   <= finish;
      launch_err  <= launch_fire && !req_ok;
      outstanding <= out_next;
      if (launch_fire && req_ok) begin
        active     <= 1'b1;
        all_loaded <= 1'b0;
        nxt        <= '0;
        lim.x      <= launch_grid_x;
        lim.y      <= launch_grid_y;
        blk_thr    <= THR_W'(req_size);
        blk_smem   <= launch_smem;
      end
      if (finish) active <= 1'b0;
      if (load) begin
        disp_valid <= 1'b1;
        disp_id    <= nxt;
        disp_slot  <= sel;
        rr_ptr     <= (sel == IDX_W'(NUM_SLOTS-1)) ? '0 : sel + 1'b1;
        if (last_blk) all_loaded <= 1'b1;
        if (nxt.x == lim.x - 1'b1) begin
          nxt.x <= '0;
          nxt.y <= nxt.y + 1'b1;
        end else begin
          nxt.x <= nxt.x + 1'b1;
        end
      end else if (disp_valid && disp_ready) begin
        disp_valid <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !disp_valid); // R1
  AST_REJECT_NO_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    launch_err |-> !active); // R2
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_id) && $stable(disp_slot)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |=> !grid_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> launch_ready); // R9
endmodule

// File: tb/tb_wd_block_dist.sv
module tb_wd_block_dist;
  localparam int NS = 4;
  localparam int TW = 10;
  localparam int SW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic launch_valid = 1'b0, launch_ready, launch_err;
  logic [7:0] l_gx = '0, l_gy = '0;
  logic [9:0] l_bx = '0, l_by = '0, l_bz = '0;
  logic [SW-1:0] l_smem = '0;
  logic disp_valid, disp_ready = 1'b0;
  logic [1:0] disp_slot;
  logic [7:0] disp_blk_x, disp_blk_y;
  logic [TW-1:0] disp_threads;
  logic [SW-1:0] disp_smem;
  logic [NS-1:0] done_valid = '0;
  logic [NS*TW-1:0] done_threads = '0;
  logic [NS*SW-1:0] done_smem = '0;
  logic grid_done;

  wd_block_dist dut (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_grid_x(l_gx), .launch_grid_y(l_gy),
    .launch_blk_x(l_bx), .launch_blk_y(l_by), .launch_blk_z(l_bz),
    .launch_smem(l_smem), .launch_err(launch_err),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
    .disp_blk_x(disp_blk_x), .disp_blk_y(disp_blk_y),
    .disp_threads(disp_threads), .disp_smem(disp_smem),
    .done_valid(done_valid), .done_threads(done_threads), .done_smem(done_smem),
    .grid_done(grid_done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  bit m_active = 0, exp_gd = 0, exp_err = 0;
  int m_gx, m_gy, m_size, m_smem, m_next, m_total, m_out;
  int m_ft[NS], m_fs[NS], m_cnt[NS];
  int rr_exp = 0;
  bit rr_mode = 0, comp_en = 1, rnd_ready = 0;
  bit prev_stall = 0;
  int prev_x, prev_y, prev_slot;
  logic [15:0] lfsr = 16'hACE1;
  bit lp = 0;
  int lp_gx, lp_gy, lp_bx, lp_by, lp_bz, lp_sm;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit params_ok(int gx, int gy, int bx, int by, int bz, int sm);
    int sz = bx*by*bz;
    return (sz >= 1) && (sz <= 512) && (sm <= 16384) && (gx > 0) && (gy > 0);
  endfunction

  task automatic step();
    int nd;
    bit was_ready;
    @(negedge clk);
    was_ready = launch_ready;
    check(launch_ready == !m_active, "R1 launch_ready vs grid state", launch_ready, !m_active);
    check(grid_done == exp_gd, "R9 grid_done timing", grid_done, exp_gd);
    check(launch_err == exp_err, "R2 launch_err", launch_err, exp_err);
    if (disp_valid) begin
      check(m_active, "R1 dispatch with no grid", 1, 0);
      if (prev_stall)
        check(disp_blk_x == prev_x && disp_blk_y == prev_y && disp_slot == prev_slot,
              "R6 payload hold", int'(disp_blk_y)*256 + disp_blk_x, prev_y*256 + prev_x);
      if (m_active) begin
        check(int'(disp_blk_y)*m_gx + int'(disp_blk_x) == m_next && disp_blk_x < m_gx,
              "R5 raster id", int'(disp_blk_y)*m_gx + int'(disp_blk_x), m_next);
        check(disp_threads == m_size, "R3 disp_threads", disp_threads, m_size);
        check(m_ft[disp_slot] >= m_size, "R3 thread room", m_ft[disp_slot], m_size);
        check(m_fs[disp_slot] >= m_smem, "R4 smem room", m_fs[disp_slot], m_smem);
      end
      if (rr_mode) check(disp_slot == rr_exp, "R7 round-robin slot", disp_slot, rr_exp);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    exp_gd = 0; exp_err = 0;
    // completions first: they concern blocks already handed over
    nd = 0;
    done_valid = '0;
    for (int s = 0; s < NS; s++) begin
      if (comp_en && m_cnt[s] > 0 && (!rnd_ready || lfsr[s+1])) begin
        done_valid[s] = 1'b1;
        done_threads[s*TW +: TW] = TW'(m_size);
        done_smem[s*SW +: SW] = SW'(m_smem);
        m_ft[s] += m_size; m_fs[s] += m_smem; m_cnt[s]--; m_out--; nd++;
      end
    end
    disp_ready = rnd_ready ? lfsr[0] : 1'b1;
    prev_stall = disp_valid && !disp_ready;
    prev_x = disp_blk_x; prev_y = disp_blk_y; prev_slot = disp_slot;
    if (disp_valid && disp_ready && m_active) begin
      m_ft[disp_slot] -= m_size; m_fs[disp_slot] -= m_smem;
      m_cnt[disp_slot]++; m_out++; m_next++;
      rr_exp = (int'(disp_slot) + 1) % NS;
    end
    if (m_active && nd > 0 && m_next == m_total && m_out == 0) begin
      exp_gd = 1; m_active = 0;
    end
    launch_valid = 1'b0;
    if (lp) begin
      launch_valid = 1'b1;
      l_gx = 8'(lp_gx); l_gy = 8'(lp_gy);
      l_bx = 10'(lp_bx); l_by = 10'(lp_by); l_bz = 10'(lp_bz); l_smem = SW'(lp_sm);
      if (was_ready) begin
        lp = 0;
        if (params_ok(lp_gx, lp_gy, lp_bx, lp_by, lp_bz, lp_sm)) begin
          m_active = 1; m_gx = lp_gx; m_gy = lp_gy;
          m_size = lp_bx*lp_by*lp_bz; m_smem = lp_sm;
          m_next = 0; m_total = lp_gx*lp_gy; m_out = 0;
        end else begin
          exp_err = 1;
        end
      end
    end
  endtask

  task automatic post(int gx, int gy, int bx, int by, int bz, int sm);
    lp = 1; lp_gx = gx; lp_gy = gy; lp_bx = bx; lp_by = by; lp_bz = bz; lp_sm = sm;
  endtask

  task automatic drain();
    while (lp || m_active) begin
      step();
      if (rr_mode && m_next == m_total) comp_en = 1;
    end
    step(); step();
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin m_ft[s] = 768; m_fs[s] = 16384; m_cnt[s] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(launch_ready == 1'b1, "R10 reset launch_ready", launch_ready, 1);
    check(disp_valid == 1'b0, "R10 reset disp_valid", disp_valid, 0);
    check(grid_done == 1'b0, "R10 reset grid_done", grid_done, 0);
    check(launch_err == 1'b0, "R10 reset launch_err", launch_err, 0);

    // R7: round-robin from slot 0, completions held until all issued
    rr_mode = 1; comp_en = 0; rnd_ready = 0;
    post(8, 1, 32, 1, 1, 0);
    drain();
    rr_mode = 0; comp_en = 1;

    // R2: rejected shapes and requests
    post(2, 2, 8, 8, 9, 0);      drain();  // 576 threads
    post(2, 2, 4, 0, 1, 0);      drain();  // zero extent
    post(2, 2, 4, 4, 1, 16385);  drain();  // smem too large
    post(0, 3, 4, 4, 1, 0);      drain();  // zero grid width

    // R3/R8: 512-thread blocks, one per slot, slots must be reused
    rnd_ready = 1;
    post(3, 3, 16, 16, 2, 16384);
    drain();
    check(m_next == 9, "R8 all blocks issued after reuse", m_next, 9);

    // R4: shared memory limits residency while threads are plentiful
    post(4, 4, 64, 1, 1, 8192);
    drain();
    check(m_next == 16, "R4 all blocks issued", m_next, 16);

    // R1/R9: second launch waits behind a running grid
    post(5, 2, 8, 4, 2, 1000);
    while (!m_active) step();
    post(3, 3, 7, 1, 1, 300);
    drain();
    check(m_next == 9, "R1 queued grid completed", m_next, 9);

    // R5: tall grid, always-ready path
    rnd_ready = 0;
    post(2, 7, 100, 3, 1, 4000);
    drain();
    check(m_next == 14, "R5 all blocks issued", m_next, 14);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule